// File: doc/BRIEF.md
# CAN Interframe Space Sequencer

This block tracks the gap between CAN frames for one node. A frame-level controller tells it when the end-of-frame field has finished. The block then counts the intermission bits. If the node sent the previous frame while it was error passive, it also counts a suspend-transmission window. Once the gap is over, it decides whether the node opens its own pending frame or follows another node's start-of-frame as a receiver.

The block advances only on a bit-sample strobe supplied by the bit-timing logic. It reads the sampled bus level on each strobe, where 1 means recessive. It reports the field it is in, pulses a start-of-frame request when the node should drive its own frame, and holds transmitter and receiver role flags until the next end-of-frame. A dominant bit too early in intermission is flagged as an overload. The block then waits for the end of the overload frame, signalled on the same end-of-frame input.

Top module: `can_ifs_seq`

## Requirements
- R1: A synchronous reset puts the block in bus idle (`field_st` = 0) with `is_rx`, `is_tx`, `sof_tx` and `ovl` all low.
- R2: Without a `bit_smp` strobe, `field_st` and both role flags keep their values, and `sof_tx` and `ovl` stay low, whatever the other inputs do.
- R3: `eof_done` sampled in a frame (`field_st` = 3) starts intermission (`field_st` = 1), which lasts exactly 3 recessive strobes.
- R4: The node is error passive when `tec` ≥ 128 or `rec` ≥ 128, judged when `eof_done` is taken. A passive node that has `was_tx` set enters suspend (`field_st` = 2) after intermission. Every other node goes from intermission straight to idle (`field_st` = 0).
- R5: For a node without suspend, a frame pending on the last intermission strobe gives `sof_tx` for one clock after that strobe, with `is_tx` high and `field_st` = 3.
- R6: A frame that first becomes pending on the first idle strobe after intermission gives `sof_tx` on that strobe, one bit later than in R5.
- R7: A dominant strobe during suspend makes the node a receiver (`is_rx`, `field_st` = 3) with no `sof_tx`. A frame still pending after that frame ends is started at the next opportunity.
- R8: The suspend field lasts 8 recessive strobes. A suspended node with a pending frame raises `sof_tx` only on the 8th strobe, never earlier in intermission or suspend.
- R9: A dominant third intermission strobe counts as start-of-frame. The node becomes transmitter with `sof_tx` if a frame is pending and no suspend applies; otherwise it becomes receiver.
- R10: A dominant first or second intermission strobe pulses `ovl` for one clock and enters overload (`field_st` = 4). The next `eof_done` strobe restarts intermission.
- R11: In idle with nothing pending, a dominant strobe makes the node a receiver with `field_st` = 3 and no `sof_tx`.
- R12: `eof_done` taken in a frame clears both role flags.
- R13: `is_rx` and `is_tx` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_smp | input | 1 | One-clock strobe at each bit sample point |
| bus_lvl | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| eof_done | input | 1 | Last bit of end-of-frame (or overload delimiter) sampled |
| was_tx | input | 1 | Node transmitted the frame now ending |
| tec | input | ERR_W | Transmit error counter |
| rec | input | ERR_W | Receive error counter |
| tx_pend | input | 1 | A frame is waiting to be sent |
| sof_tx | output | 1 | One-clock request to drive start-of-frame next bit |
| is_rx | output | 1 | Node is receiver of current frame |
| is_tx | output | 1 | Node is transmitter of current frame |
| ovl | output | 1 | One-clock overload indication |
| field_st | output | 3 | 0 idle, 1 intermission, 2 suspend, 3 frame, 4 overload |

## Verification
A wrong bit counter shows at `field_st` within one strobe: the field would be left early or late relative to the counted bits. A wrongly latched suspend decision appears three strobes after end-of-frame, as a suspend state where idle was due or the reverse. A role or start decision taken on the wrong bit shows as `sof_tx` on the wrong strobe, or as `is_rx` and `is_tx` swapped, in the clock right after that strobe. The directed scenarios probe each bit position of both windows at its boundary for that reason.

// File: rtl/can_ifs_seq.sv
module can_ifs_seq #(
  parameter int IMS_BITS    = 3,
  parameter int SUSP_BITS   = 8,
  parameter int ERR_W       = 9,
  parameter int PASSIVE_LIM = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_smp,
  input  logic             bus_lvl,
  input  logic             eof_done,
  input  logic             was_tx,
  input  logic [ERR_W-1:0] tec,
  input  logic [ERR_W-1:0] rec,
  input  logic             tx_pend,
  output logic             sof_tx,
  output logic             is_rx,
  output logic             is_tx,
  output logic             ovl,
  output logic [2:0]       field_st
);

  localparam int CNT_MAX = (IMS_BITS > SUSP_BITS) ? IMS_BITS : SUSP_BITS;
  localparam int CW = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CW-1:0] IMS_LAST  = CW'(IMS_BITS - 1);
  localparam logic [CW-1:0] SUSP_LAST = CW'(SUSP_BITS - 1);
  localparam logic [ERR_W-1:0] LIM = ERR_W'(PASSIVE_LIM);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_IMS  = 3'd1;
  localparam logic [2:0] S_SUSP = 3'd2;
  localparam logic [2:0] S_FRM  = 3'd3;
  localparam logic [2:0] S_OVL  = 3'd4;

  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic          susp_q;

  wire dom     = ~bus_lvl;
  wire passive = (tec >= LIM) || (rec >= LIM);

  assign field_st = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      susp_q <= 1'b0;
      is_rx  <= 1'b0;
      is_tx  <= 1'b0;
      sof_tx <= 1'b0;
      ovl    <= 1'b0;
    end else begin
      sof_tx <= 1'b0;
      ovl    <= 1'b0;
      if (bit_smp) begin
        case (st)
          S_IDLE: begin
            if (tx_pend) begin
              st <= S_FRM; is_tx <= 1'b1; sof_tx <= 1'b1;
            end else if (dom) begin
              st <= S_FRM; is_rx <= 1'b1;
            end
          end
          S_IMS: begin
            if (dom) begin
              if (cnt == IMS_LAST) begin
                st <= S_FRM;
                if (tx_pend && !susp_q) begin
                  is_tx <= 1'b1; sof_tx <= 1'b1;
                end else begin
                  is_rx <= 1'b1;
                end
              end else begin
                st  <= S_OVL;
                ovl <= 1'b1;
              end
            end else if (cnt == IMS_LAST) begin
              cnt <= '0;
              if (susp_q) begin
                st <= S_SUSP;
              end else if (tx_pend) begin
                st <= S_FRM; is_tx <= 1'b1; sof_tx <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_SUSP: begin
            if (dom) begin
              st <= S_FRM; is_rx <= 1'b1; susp_q <= 1'b0;
            end else if (cnt == SUSP_LAST) begin
              susp_q <= 1'b0;
              if (tx_pend) begin
                st <= S_FRM; is_tx <= 1'b1; sof_tx <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_FRM: begin
            if (eof_done) begin
              st     <= S_IMS;
              cnt    <= '0;
              susp_q <= was_tx && passive;
              is_rx  <= 1'b0;
              is_tx  <= 1'b0;
            end
          end
          S_OVL: begin
            if (eof_done) begin
              st  <= S_IMS;
              cnt <= '0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module can_ifs_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_smp,
  input logic       bus_lvl,
  input logic       tx_pend,
  input logic       sof_tx,
  input logic       is_rx,
  input logic       is_tx,
  input logic       ovl,
  input logic [2:0] field_st
);

  p_roles_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(is_rx && is_tx));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_smp |=> $stable(field_st) && $stable(is_rx) && $stable(is_tx) && !sof_tx && !ovl);

  p_sof_tx_r5: assert property (@(posedge clk) disable iff (rst)
    sof_tx |-> is_tx && field_st == 3'd3);

  p_yield_r7: assert property (@(posedge clk) disable iff (rst)
    (field_st == 3'd2 && bit_smp && !bus_lvl) |=> is_rx && !sof_tx);

  p_idle_rx_r11: assert property (@(posedge clk) disable iff (rst)
    (field_st == 3'd0 && bit_smp && !bus_lvl && !tx_pend) |=> is_rx && field_st == 3'd3);

  p_ovl_r10: assert property (@(posedge clk) disable iff (rst)
    ovl |-> field_st == 3'd4);

endmodule

bind can_ifs_seq can_ifs_seq_chk u_chk (.*);

// File: tb/tb_can_ifs_seq.sv
module tb_can_ifs_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_smp = 1'b0, bus_lvl = 1'b1, eof_done = 1'b0, was_tx = 1'b0, tx_pend = 1'b0;
  logic [8:0] tec = '0, rec = '0;
  logic sof_tx, is_rx, is_tx, ovl;
  logic [2:0] field_st;
  int n_run = 0, n_fail = 0;
  logic last_sof, last_ovl;

  always #5 clk = ~clk;

  can_ifs_seq dut (.clk(clk), .rst(rst), .bit_smp(bit_smp), .bus_lvl(bus_lvl),
    .eof_done(eof_done), .was_tx(was_tx), .tec(tec), .rec(rec), .tx_pend(tx_pend),
    .sof_tx(sof_tx), .is_rx(is_rx), .is_tx(is_tx), .ovl(ovl), .field_st(field_st));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic lvl, input logic eof, input logic pend);
    @(negedge clk);
    bus_lvl = lvl; eof_done = eof; tx_pend = pend; bit_smp = 1'b1;
    @(negedge clk);
    bit_smp = 1'b0; eof_done = 1'b0;
    last_sof = sof_tx; last_ovl = ovl;
  endtask

  task automatic go_tx();
    strobe(1'b1, 1'b0, 1'b1);
    chk("R5 start tx sof", int'(last_sof), 1);
  endtask

  task automatic end_frame(input logic wtx, input logic [8:0] t, input logic [8:0] r, input logic pend);
    was_tx = wtx; tec = t; rec = r;
    strobe(1'b1, 1'b1, pend);
    chk("R12 roles cleared", int'({is_rx, is_tx}), 0);
    chk("R3 intermission entered", int'(field_st), 1);
  endtask

  task automatic drain();
    end_frame(1'b0, 9'd0, 9'd0, 1'b0);
    repeat (3) strobe(1'b1, 1'b0, 1'b0);
    chk("R4 idle after drain", int'(field_st), 0);
  endtask

  task automatic t_reset();
    chk("R1 field", int'(field_st), 0);
    chk("R1 roles", int'({is_rx, is_tx}), 0);
    chk("R1 sof/ovl", int'({sof_tx, ovl}), 0);
  endtask

  task automatic t_no_strobe();
    @(negedge clk); bus_lvl = 1'b0; tx_pend = 1'b1; eof_done = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 field held", int'(field_st), 0);
    chk("R2 roles held", int'({is_rx, is_tx}), 0);
    chk("R2 no sof", int'(sof_tx), 0);
    bus_lvl = 1'b1; tx_pend = 1'b0; eof_done = 1'b0;
  endtask

  task automatic t_active_ifs();
    go_tx();
    chk("R5 tx role", int'({is_rx, is_tx}), 1);
    end_frame(1'b1, 9'd127, 9'd127, 1'b0);
    strobe(1'b1, 1'b0, 1'b0); chk("R3 ims bit1", int'(field_st), 1);
    strobe(1'b1, 1'b0, 1'b0); chk("R3 ims bit2", int'(field_st), 1);
    strobe(1'b1, 1'b0, 1'b0); chk("R4 active to idle", int'(field_st), 0);
  endtask

  task automatic t_passive_rx();
    go_tx();
    end_frame(1'b0, 9'd0, 9'd200, 1'b0);
    repeat (3) strobe(1'b1, 1'b0, 1'b0);
    chk("R4 receiver no suspend", int'(field_st), 0);
  endtask

  task automatic t_suspend_len();
    go_tx();
    end_frame(1'b1, 9'd0, 9'd130, 1'b0);
    repeat (3) strobe(1'b1, 1'b0, 1'b0);
    chk("R4 suspend entered", int'(field_st), 2);
    for (int i = 0; i < 7; i++) strobe(1'b1, 1'b0, 1'b0);
    chk("R8 suspend after 7", int'(field_st), 2);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R8 idle after 8", int'(field_st), 0);
  endtask

  task automatic t_pend_last();
    go_tx();
    end_frame(1'b1, 9'd0, 9'd0, 1'b0);
    strobe(1'b1, 1'b0, 1'b0); strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b1, 1'b0, 1'b1);
    chk("R5 sof on last ims bit", int'(last_sof), 1);
    chk("R5 tx frame", int'({field_st, is_tx}), 7);
    drain();
  endtask

  task automatic t_pend_idle();
    go_tx();
    end_frame(1'b1, 9'd0, 9'd0, 1'b0);
    repeat (3) strobe(1'b1, 1'b0, 1'b0);
    chk("R6 no sof at ims end", int'(last_sof), 0);
    strobe(1'b1, 1'b0, 1'b1);
    chk("R6 sof first idle bit", int'(last_sof), 1);
    drain();
  endtask

  task automatic t_yield();
    int sofs = 0;
    go_tx();
    end_frame(1'b1, 9'd150, 9'd0, 1'b1);
    for (int i = 0; i < 6; i++) begin strobe(1'b1, 1'b0, 1'b1); sofs += int'(last_sof); end
    chk("R7 no sof before yield", sofs, 0);
    strobe(1'b0, 1'b0, 1'b1);
    chk("R7 receiver", int'({is_rx, is_tx}), 2);
    chk("R7 no sof", int'(last_sof), 0);
    chk("R7 frame", int'(field_st), 3);
    end_frame(1'b0, 9'd150, 9'd0, 1'b1);
    strobe(1'b1, 1'b0, 1'b1); strobe(1'b1, 1'b0, 1'b1); strobe(1'b1, 1'b0, 1'b1);
    chk("R7 later attempt sof", int'(last_sof), 1);
    drain();
  endtask

  task automatic t_susp_sof();
    int sofs = 0;
    go_tx();
    end_frame(1'b1, 9'd128, 9'd0, 1'b1);
    for (int i = 0; i < 10; i++) begin strobe(1'b1, 1'b0, 1'b1); sofs += int'(last_sof); end
    chk("R8 no early sof", sofs, 0);
    chk("R8 still suspend", int'(field_st), 2);
    strobe(1'b1, 1'b0, 1'b1);
    chk("R8 sof at 8th", int'(last_sof), 1);
    chk("R8 tx", int'(is_tx), 1);
    drain();
  endtask

  task automatic t_dom_third();
    go_tx();
    end_frame(1'b0, 9'd0, 9'd0, 1'b0);
    strobe(1'b1, 1'b0, 1'b0); strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b0, 1'b0, 1'b0);
    chk("R9 rx at third", int'({is_rx, is_tx, last_ovl}), 4);
    end_frame(1'b0, 9'd0, 9'd0, 1'b0);
    strobe(1'b1, 1'b0, 1'b0); strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b0, 1'b0, 1'b1);
    chk("R9 tx at third", int'({is_rx, is_tx, last_sof}), 3);
    end_frame(1'b1, 9'd200, 9'd0, 1'b1);
    strobe(1'b1, 1'b0, 1'b1); strobe(1'b1, 1'b0, 1'b1);
    strobe(1'b0, 1'b0, 1'b1);
    chk("R9 suspended rx at third", int'({is_rx, is_tx, last_sof}), 4);
    drain();
  endtask

  task automatic t_overload();
    go_tx();
    end_frame(1'b0, 9'd0, 9'd0, 1'b0);
    strobe(1'b0, 1'b0, 1'b0);
    chk("R10 ovl pulse", int'(last_ovl), 1);
    chk("R10 overload field", int'(field_st), 4);
    @(negedge clk);
    chk("R10 ovl one clock", int'(ovl), 0);
    strobe(1'b1, 1'b0, 1'b0);
    chk("R10 stays overload", int'(field_st), 4);
    strobe(1'b1, 1'b1, 1'b0);
    chk("R10 ims restart", int'(field_st), 1);
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b0, 1'b0, 1'b0);
    chk("R10 second bit ovl", int'({last_ovl, field_st}), 12);
    strobe(1'b1, 1'b1, 1'b0);
    repeat (3) strobe(1'b1, 1'b0, 1'b0);
    chk("R10 back idle", int'(field_st), 0);
  endtask

  task automatic t_idle_rx();
    strobe(1'b0, 1'b0, 1'b0);
    chk("R11 receiver", int'({is_rx, is_tx}), 2);
    chk("R11 frame no sof", int'({field_st, last_sof}), 6);
    chk("R13 exclusive", int'(is_rx && is_tx), 0);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_strobe();
    t_active_ifs();
    t_passive_rx();
    t_suspend_len();
    t_pend_last();
    t_pend_idle();
    t_yield();
    t_susp_sof();
    t_dom_third();
    t_overload();
    t_idle_rx();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule